// File: doc/BRIEF.md
# Two-Phase ZQ Calibration Scheduler

This block runs runtime impedance (ZQ) calibration for an LPDDR4-class memory controller as two separate commands. On a trigger it asks the controller's command arbiter for the bus and issues a calibration-start command. It then lets go of the bus for the whole calibration window so that normal traffic keeps flowing. Once the window has passed it asks for the bus again and issues the latch command, which applies the new impedance values. It then waits out the latch settle time and signals completion with a one-cycle pulse.

Both commands go out on one DFI-style command slot as a multipurpose command. Bank is zero and the 7-bit operand sits on the low address bits. The wait lengths are computed from a clock-period parameter, in picoseconds, when the block is elaborated. A periodic interval source outside the block drives the trigger. A trigger that arrives while a calibration is in progress is remembered and served exactly once afterwards.

Top module: `zq_sched`

## Requirements
- R1: After reset, req, busy and done are 0, and the command slot is deselected: cmdCsN=1, cmdRasN=1, cmdCasN=1, cmdWeN=1, cmdBank=0, cmdAddr=0.
- R2: A trigger sampled while idle raises req and busy in the next cycle.
- R3: req stays high until grant is seen. A command is issued only in a cycle where req and grant are both high. In every other cycle the slot stays deselected, whether or not grant is high.
- R4: An issued command is driven with cmdCsN=0, cmdRasN=1, cmdCasN=1, cmdWeN=0 and cmdBank=0. The operand is on cmdAddr[6:0] and the upper address bits are 0.
- R5: The first command of each calibration carries operand 7'b1001111 (start). The second carries 7'b1010001 (latch).
- R6: Between the start and latch commands, req is low. The latch request is raised CAL_CYC+1 cycles after the start issue cycle, where CAL_CYC = ceil(T_CAL_PS / CLK_PERIOD_PS). The latch is therefore never issued fewer than CAL_CYC cycles after the start.
- R7: done pulses for exactly one cycle, LAT_CYC cycles after the latch issue cycle, where LAT_CYC = max(LAT_MIN_CK, ceil(T_LAT_PS / CLK_PERIOD_PS)). busy is low in the cycle after done.
- R8: busy is high from the first request cycle through the done cycle.
- R9: Triggers that arrive while busy are merged into a single pending request. That request starts exactly one more calibration after the current one, with one idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Calibration trigger pulse |
| grant | input | 1 | Arbiter grant of the command slot |
| req | output | 1 | Request for the command slot |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| cmdCsN | output | 1 | Command chip select, active low |
| cmdRasN | output | 1 | Command RAS, active low |
| cmdCasN | output | 1 | Command CAS, active low |
| cmdWeN | output | 1 | Command write enable, active low |
| cmdBank | output | BANK_W | Command bank |
| cmdAddr | output | ADDR_W | Command address, operand on bits 6:0 |

## Verification
The assertions assume the arbiter grants only while a request is visible, or at least that a grant given in any other cycle has no meaning. They also assume that trig is a level sampled each cycle, with no protocol of its own. The bench drives grant freely, including holding it high through the wait windows and delaying it for several cycles, so the block must ignore grant whenever it is not requesting. Triggers are applied at idle, mid-window and repeatedly during a run, to exercise how pending requests are merged.

// File: rtl/zqs_pkg.sv
package zqs_pkg;

  typedef enum logic [2:0] {
    ZS_IDLE,
    ZS_REQ_START,
    ZS_WAIT_CAL,
    ZS_REQ_LATCH,
    ZS_WAIT_LAT
  } zqsState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCal;
    logic loadLat;
    logic issueStart;
    logic issueLatch;
  } zqsStrobe_t;

  localparam logic [6:0] OP_CAL_START = 7'b1001111;
  localparam logic [6:0] OP_CAL_LATCH = 7'b1010001;
  localparam int         OP_W         = 7;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/zqs_ctrl.sv
module zqs_ctrl
  import zqs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  input  logic       grant,
  input  logic       cntZero,
  output logic       req,
  output logic       busy,
  output logic       done,
  output zqsStrobe_t strobe
);

  zqsState_t state, stateNext;
  logic      pending;

  always_comb begin
    stateNext = state;
    unique case (state)
      ZS_IDLE:      if (trig || pending) stateNext = ZS_REQ_START;
      ZS_REQ_START: if (grant)           stateNext = ZS_WAIT_CAL;
      ZS_WAIT_CAL:  if (cntZero)         stateNext = ZS_REQ_LATCH;
      ZS_REQ_LATCH: if (grant)           stateNext = ZS_WAIT_LAT;
      ZS_WAIT_LAT:  if (cntZero)         stateNext = ZS_IDLE;
      default:                           stateNext = ZS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ZS_IDLE;
      pending <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ZS_IDLE) pending <= 1'b0;
      else if (trig)        pending <= 1'b1;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.issueStart = (state == ZS_REQ_START) && grant;
    strobe.issueLatch = (state == ZS_REQ_LATCH) && grant;
    strobe.loadCal    = strobe.issueStart;
    strobe.loadLat    = strobe.issueLatch;
  end

  assign req  = (state == ZS_REQ_START) || (state == ZS_REQ_LATCH);
  assign busy = (state != ZS_IDLE);
  assign done = (state == ZS_WAIT_LAT) && cntZero;

endmodule

// File: rtl/zqs_datapath.sv
module zqs_datapath
  import zqs_pkg::*;
#(
  parameter int CAL_CYC = 800,
  parameter int LAT_CYC = 24,
  parameter int BANK_W  = 3,
  parameter int ADDR_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  zqsStrobe_t        strobe,
  output logic              cntZero,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr
);

  localparam int CNT_MAX = maxOf(CAL_CYC, LAT_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] waitCnt;
  logic             issue;
  logic [OP_W-1:0]  operand;

  always_ff @(posedge clk) begin
    if (!rst_n)                waitCnt <= '0;
    else if (strobe.loadCal)   waitCnt <= CNT_W'(CAL_CYC - 1);
    else if (strobe.loadLat)   waitCnt <= CNT_W'(LAT_CYC - 1);
    else if (waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
  end

  assign cntZero = (waitCnt == '0);

  assign issue   = strobe.issueStart || strobe.issueLatch;
  assign operand = strobe.issueLatch ? OP_CAL_LATCH :
                   strobe.issueStart ? OP_CAL_START : '0;

  assign cmdCsN  = !issue;
  assign cmdRasN = 1'b1;
  assign cmdCasN = 1'b1;
  assign cmdWeN  = !issue;
  assign cmdBank = '0;

  generate
    if (ADDR_W > OP_W) begin : g_padAddr
      assign cmdAddr = {{(ADDR_W-OP_W){1'b0}}, operand};
    end else begin : g_exactAddr
      assign cmdAddr = operand;
    end
  endgenerate

endmodule

// File: rtl/zq_sched.sv
module zq_sched
  import zqs_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 1250,
  parameter int T_CAL_PS      = 1000000,
  parameter int T_LAT_PS      = 30000,
  parameter int LAT_MIN_CK    = 8,
  parameter int BANK_W        = 3,
  parameter int ADDR_W        = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              grant,
  output logic              req,
  output logic              busy,
  output logic              done,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr
);

  localparam int CAL_CYC = maxOf(1, ceilDiv(T_CAL_PS, CLK_PERIOD_PS));
  localparam int LAT_CYC = maxOf(LAT_MIN_CK, ceilDiv(T_LAT_PS, CLK_PERIOD_PS));

  zqsStrobe_t strobe;
  logic       cntZero;

  zqs_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .grant   (grant),
    .cntZero (cntZero),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .strobe  (strobe)
  );

  zqs_datapath #(
    .CAL_CYC (CAL_CYC),
    .LAT_CYC (LAT_CYC),
    .BANK_W  (BANK_W),
    .ADDR_W  (ADDR_W)
  ) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .cntZero (cntZero),
    .cmdCsN  (cmdCsN),
    .cmdRasN (cmdRasN),
    .cmdCasN (cmdCasN),
    .cmdWeN  (cmdWeN),
    .cmdBank (cmdBank),
    .cmdAddr (cmdAddr)
  );

endmodule

// File: rtl/zq_sched_chk.sv
module zq_sched_chk #(
  parameter int CAL_CYC = 800,
  parameter int LAT_CYC = 24,
  parameter int BANK_W  = 3,
  parameter int ADDR_W  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant,
  input logic              req,
  input logic              busy,
  input logic              done,
  input logic              cmdCsN,
  input logic              cmdRasN,
  input logic              cmdCasN,
  input logic              cmdWeN,
  input logic [BANK_W-1:0] cmdBank,
  input logic [ADDR_W-1:0] cmdAddr
);

  logic        cmdOn, startOn, latchOn, expectLatch;
  logic [31:0] sinceStart, sinceLatch;

  assign cmdOn   = !cmdCsN;
  assign startOn = cmdOn && (cmdAddr[6:0] == 7'b1001111);
  assign latchOn = cmdOn && (cmdAddr[6:0] == 7'b1010001);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expectLatch <= 1'b0;
      sinceStart  <= '0;
      sinceLatch  <= '0;
    end else begin
      if (startOn) expectLatch <= 1'b1;
      else if (latchOn) expectLatch <= 1'b0;
      sinceStart <= startOn ? 32'd1 : (sinceStart == '1 ? sinceStart : sinceStart + 1);
      sinceLatch <= latchOn ? 32'd1 : (sinceLatch == '1 ? sinceLatch : sinceLatch + 1);
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant) |=> req);
  p_cmd_only_on_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmdOn |-> (req && grant));
  p_cmd_encoding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmdOn |-> (cmdRasN && cmdCasN && !cmdWeN && cmdBank == '0 && (cmdAddr >> 7) == '0));
  p_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmdOn |-> (startOn || latchOn));
  p_order_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    startOn |-> !expectLatch);
  p_order_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latchOn |-> expectLatch);
  p_cal_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latchOn |-> (sinceStart >= 32'(CAL_CYC)));
  p_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!expectLatch && sinceLatch >= 32'(LAT_CYC)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_busy_on_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req || done) |-> busy);

endmodule

bind zq_sched zq_sched_chk #(
  .CAL_CYC (CAL_CYC),
  .LAT_CYC (LAT_CYC),
  .BANK_W  (BANK_W),
  .ADDR_W  (ADDR_W)
) i_zq_sched_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .grant   (grant),
  .req     (req),
  .busy    (busy),
  .done    (done),
  .cmdCsN  (cmdCsN),
  .cmdRasN (cmdRasN),
  .cmdCasN (cmdCasN),
  .cmdWeN  (cmdWeN),
  .cmdBank (cmdBank),
  .cmdAddr (cmdAddr)
);

// File: tb/test_zq_sched.sv
`timescale 1ns/1ps
module test_zq_sched;

  localparam int CLK_NS  = 10;
  localparam int BANK_W  = 3;
  localparam int ADDR_W  = 17;
  // 10 ns clock: ceil(1000 ns / 10) = 100, max(8, ceil(30 / 10)) = 8
  localparam int EXP_CAL = 100;
  localparam int EXP_LAT = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trig = 1'b0;
  logic              grant = 1'b0;
  logic              req, busy, done;
  logic              cmdCsN, cmdRasN, cmdCasN, cmdWeN;
  logic [BANK_W-1:0] cmdBank;
  logic [ADDR_W-1:0] cmdAddr;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zq_sched #(
    .CLK_PERIOD_PS (CLK_NS * 1000),
    .BANK_W        (BANK_W),
    .ADDR_W        (ADDR_W)
  ) i_zq_sched (
    .clk (clk), .rst_n (rst_n), .trig (trig), .grant (grant),
    .req (req), .busy (busy), .done (done),
    .cmdCsN (cmdCsN), .cmdRasN (cmdRasN), .cmdCasN (cmdCasN), .cmdWeN (cmdWeN),
    .cmdBank (cmdBank), .cmdAddr (cmdAddr)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // advance to next negedge and settle
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic checkDeselect(input string tag);
    check(cmdCsN && cmdRasN && cmdCasN && cmdWeN, {tag, " slot deselected"},
          {cmdCsN, cmdRasN, cmdCasN, cmdWeN}, 4'b1111);
  endtask

  task automatic checkCmd(input logic [6:0] op, input string tag);
    check(!cmdCsN && cmdRasN && cmdCasN && !cmdWeN, "R4 command encoding",
          {cmdCsN, cmdRasN, cmdCasN, cmdWeN}, 4'b0110);
    check(cmdBank == '0 && (cmdAddr >> 7) == '0, "R4 bank and upper address zero",
          {cmdBank, cmdAddr}, 0);
    check(cmdAddr[6:0] == op, tag, cmdAddr[6:0], op);
  endtask

  // one full calibration; the trigger must already have been applied
  task automatic runCal(input int grantDelay, input bit grantInWait, input bit extraTrig);
    int c0, c1, guard;
    check(req && busy, "R2 req and busy after trigger", {req, busy}, 2'b11);
    for (int i = 0; i < grantDelay; i++) begin
      check(req, "R3 req held without grant", req, 1);
      checkDeselect("R3 no grant");
      step();
    end
    grant = 1'b1; #1;
    checkCmd(7'b1001111, "R5 start operand");
    c0 = cyc;
    step();
    grant = grantInWait;
    guard = 0;
    while (!req && guard < 1000) begin
      check(busy, "R8 busy during calibration wait", busy, 1);
      checkDeselect("R3 during cal wait");
      if (extraTrig && guard == 10) begin trig = 1'b1; step(); trig = 1'b0; end
      else if (extraTrig && guard == 20) begin trig = 1'b1; step(); trig = 1'b0; end
      else step();
      guard++;
    end
    check(cyc - c0 == EXP_CAL + 1, "R6 latch request delay", cyc - c0, EXP_CAL + 1);
    grant = 1'b0; #1;
    checkDeselect("R3 latch not yet granted");
    step();
    check(req, "R3 latch req held", req, 1);
    grant = 1'b1; #1;
    checkCmd(7'b1010001, "R5 latch operand");
    c1 = cyc;
    step();
    grant = grantInWait;
    guard = 0;
    while (!done && guard < 1000) begin
      check(busy && !req, "R8 busy without req in settle", {busy, req}, 2'b10);
      step();
      guard++;
    end
    check(cyc - c1 == EXP_LAT, "R7 done delay after latch", cyc - c1, EXP_LAT);
    check(busy, "R8 busy in done cycle", busy, 1);
    step();
    grant = 1'b0;
    check(!done && !busy, "R7 done one cycle then idle", {done, busy}, 2'b00);
  endtask

  task automatic pulseTrig();
    trig = 1'b1; step(); trig = 1'b0;
  endtask

  task automatic testReset();
    check(!req && !busy && !done, "R1 reset outputs", {req, busy, done}, 0);
    checkDeselect("R1 reset");
    check(cmdBank == '0 && cmdAddr == '0, "R1 reset bank/addr", {cmdBank, cmdAddr}, 0);
  endtask

  task automatic testIdleGrant();
    grant = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      check(!req && !busy, "R3 idle ignores grant", {req, busy}, 0);
      checkDeselect("R3 idle grant");
    end
    grant = 1'b0;
  endtask

  task automatic testBasic();
    pulseTrig();
    runCal(0, 1'b0, 1'b0);
  endtask

  task automatic testDelayedGrant();
    pulseTrig();
    runCal(4, 1'b1, 1'b0);
  endtask

  task automatic testPending();
    pulseTrig();
    runCal(1, 1'b0, 1'b1);
    // we are one cycle after done: idle cycle observed inside runCal, next is REQ_START
    step();
    check(req && busy, "R9 pending trigger starts second run", {req, busy}, 2'b11);
    runCal(0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      check(!req && !busy, "R9 merged triggers run only once", {req, busy}, 0);
      step();
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) step();
    testReset();
    rst_n = 1'b1;
    step();
    testReset();
    testIdleGrant();
    testBasic();
    testDelayedGrant();
    testPending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule